// File: doc/BRIEF.md
# Programmable FIFO Status Flag Generator

This block produces the five occupancy flags of one 512-word FIFO: Empty, Almost-Empty, Half-Full, Almost-Full and Full. It keeps its own write and read pointers, advanced by a write increment strobe on the write clock and a read increment strobe on the read clock. From the pointers it forms the occupancy and compares it against fixed boundaries and two programmable thresholds. The FIFO storage itself is outside the block.

The near-full threshold is held in a register on the write clock. The near-empty threshold is held in a register on the read clock. Both can take any value from 0 to the full depth and return to 8 on reset. A per-flag mode bit selects how each flag is presented. In direct mode the flag is the combinational result of the current occupancy. In registered mode the flag is passed through a two-flop synchronizer clocked by the port that watches it. Full, Almost-Full and Half-Full are watched by the write port. Almost-Empty and Empty are watched by the read port.

Increment strobes that would overrun the pointers are discarded. This keeps the occupancy inside 0..512 whatever the strobes do.

Top module: `fflag_gen`

## Requirements
- R1: While reset is low and after it is released, the occupancy is 0, both thresholds are 8, `empty` and `almost_empty` are 1 and `full`, `almost_full`, `half_full` are 0, in either mode.
- R2: `empty` reflects occupancy equal to 0.
- R3: `full` reflects occupancy equal to 512, and the occupancy never exceeds 512.
- R4: `half_full` reflects occupancy strictly greater than 256.
- R5: `almost_empty` reflects occupancy less than or equal to the near-empty threshold.
- R6: `almost_full` reflects free space (512 minus occupancy) less than or equal to the near-full threshold.
- R7: A write strobe while the occupancy is 512 and a read strobe while it is 0 are discarded. Such a strobe leaves the pointer and the occupancy unchanged.
- R8: A threshold write loads its data word at that clock edge, and the flags use the new value from that edge on. Values 0 and 512 are both valid.
- R9: `flag_sync_mode` holds one mode bit per flag: bit 0 full, bit 1 almost-full, bit 2 half-full, bit 3 almost-empty, bit 4 empty. A bit value of 0 shows the flag directly from the current occupancy. A bit value of 1 shows the value the flag had two edges earlier of the observing clock: the write clock for bits 0 to 2, the read clock for bits 3 and 4.
- R10: A write strobe and a read strobe in the same cycle leave the occupancy unchanged. The exceptions are full, where only the read acts, and empty, where only the write acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_inc | input | 1 | Write pointer increment strobe |
| rd_inc | input | 1 | Read pointer increment strobe |
| af_off_we | input | 1 | Load strobe for the near-full threshold (write clock) |
| af_off_wdata | input | 10 | New near-full threshold |
| ae_off_we | input | 1 | Load strobe for the near-empty threshold (read clock) |
| ae_off_wdata | input | 10 | New near-empty threshold |
| flag_sync_mode | input | 5 | Per-flag mode, 1 = registered |
| full | output | 1 | Occupancy is 512 |
| almost_full | output | 1 | Free space at or below near-full threshold |
| half_full | output | 1 | Occupancy above 256 |
| almost_empty | output | 1 | Occupancy at or below near-empty threshold |
| empty | output | 1 | Occupancy is 0 |

## Verification
The bench builds the block with its default parameters: a depth of 512, a reset threshold of 8, and therefore 10-bit thresholds. It ties both clocks to one source, so the registered flags lag by exactly two edges, which a behavioural model predicts cycle by cycle. At this depth every boundary is in reach within a few hundred cycles: full, half, empty and both extreme threshold values 0 and 512. Discarded strobes at both ends, simultaneous strobes and changes of mode mid-run are all reached.

// File: rtl/fflag_pkg.sv
package fflag_pkg;
  localparam int NFLAG      = 5;
  localparam int IDX_FULL   = 0;
  localparam int IDX_AFULL  = 1;
  localparam int IDX_HALF   = 2;
  localparam int IDX_AEMPTY = 3;
  localparam int IDX_EMPTY  = 4;

  // Occupancy from two wrap-bit pointers of pw bits.
  function automatic int unsigned occ_of(int unsigned wp, int unsigned rp, int unsigned pw);
    int unsigned mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  // All five flags from occupancy and thresholds.
  function automatic logic [NFLAG-1:0] flags_of(int unsigned occ, int unsigned depth,
                                                int unsigned af_off, int unsigned ae_off);
    logic [NFLAG-1:0] f;
    f[IDX_FULL]   = (occ == depth);
    f[IDX_AFULL]  = ((depth - occ) <= af_off);
    f[IDX_HALF]   = (occ > (depth / 2));
    f[IDX_AEMPTY] = (occ <= ae_off);
    f[IDX_EMPTY]  = (occ == 0);
    return f;
  endfunction
endpackage

// File: rtl/fflag_ptr.sv
module fflag_ptr #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          block,
  output logic [PW-1:0] ptr
);
  logic step_en;
  assign step_en = inc && !block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (step_en) ptr <= ptr + PW'(1);
  end
endmodule

// File: rtl/fflag_offset_reg.sv
module fflag_offset_reg #(
  parameter int OW      = 10,
  parameter int RST_VAL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [OW-1:0] wdata,
  output logic [OW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= OW'(RST_VAL);
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/fflag_sync2.sv
module fflag_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fflag_gen.sv
module fflag_gen #(
  parameter int DEPTH   = 512,
  parameter int OFF_RST = 8,
  parameter int OFF_W   = $clog2(DEPTH + 1)
) (
  input  logic                         wr_clk,
  input  logic                         rd_clk,
  input  logic                         rst_n,
  input  logic                         wr_inc,
  input  logic                         rd_inc,
  input  logic                         af_off_we,
  input  logic [OFF_W-1:0]             af_off_wdata,
  input  logic                         ae_off_we,
  input  logic [OFF_W-1:0]             ae_off_wdata,
  input  logic [fflag_pkg::NFLAG-1:0]  flag_sync_mode,
  output logic                         full,
  output logic                         almost_full,
  output logic                         half_full,
  output logic                         almost_empty,
  output logic                         empty
);
  import fflag_pkg::*;

  localparam int PW = $clog2(DEPTH) + 1;
  localparam logic [NFLAG-1:0] FLAG_RST =
    flags_of(32'd0, DEPTH, OFF_RST, OFF_RST);

  logic [PW-1:0]    wptr, rptr, occ;
  logic [OFF_W-1:0] af_off, ae_off;
  logic [NFLAG-1:0] flag_c, flag_s, flag_o;
  logic             full_c, af_c, hf_c, ae_c, empty_c;

  // Occupancy and direct flag values
  assign occ     = PW'(occ_of(32'(wptr), 32'(rptr), PW));
  assign flag_c  = flags_of(32'(occ), DEPTH, 32'(af_off), 32'(ae_off));
  assign full_c  = flag_c[IDX_FULL];
  assign af_c    = flag_c[IDX_AFULL];
  assign hf_c    = flag_c[IDX_HALF];
  assign ae_c    = flag_c[IDX_AEMPTY];
  assign empty_c = flag_c[IDX_EMPTY];

  // Pointers; overrunning strobes are discarded (R7)
  fflag_ptr #(.PW(PW)) u_wptr (
    .clk(wr_clk), .rst_n(rst_n), .inc(wr_inc), .block(full_c), .ptr(wptr)
  );
  fflag_ptr #(.PW(PW)) u_rptr (
    .clk(rd_clk), .rst_n(rst_n), .inc(rd_inc), .block(empty_c), .ptr(rptr)
  );

  // Threshold registers (R8)
  fflag_offset_reg #(.OW(OFF_W), .RST_VAL(OFF_RST)) u_af_off (
    .clk(wr_clk), .rst_n(rst_n), .we(af_off_we), .wdata(af_off_wdata), .q(af_off)
  );
  fflag_offset_reg #(.OW(OFF_W), .RST_VAL(OFF_RST)) u_ae_off (
    .clk(rd_clk), .rst_n(rst_n), .we(ae_off_we), .wdata(ae_off_wdata), .q(ae_off)
  );

  // Per-flag presentation: write side observes full/af/hf, read side ae/empty (R9)
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    if (g <= IDX_HALF) begin : g_wr
      fflag_sync2 #(.RST_VAL(FLAG_RST[g])) u_sync (
        .clk(wr_clk), .rst_n(rst_n), .d(flag_c[g]), .q(flag_s[g])
      );
    end else begin : g_rd
      fflag_sync2 #(.RST_VAL(FLAG_RST[g])) u_sync (
        .clk(rd_clk), .rst_n(rst_n), .d(flag_c[g]), .q(flag_s[g])
      );
    end
    assign flag_o[g] = flag_sync_mode[g] ? flag_s[g] : flag_c[g];
  end

  assign full         = flag_o[IDX_FULL];
  assign almost_full  = flag_o[IDX_AFULL];
  assign half_full    = flag_o[IDX_HALF];
  assign almost_empty = flag_o[IDX_AEMPTY];
  assign empty        = flag_o[IDX_EMPTY];
endmodule

// File: rtl/fflag_gen_chk.sv
module fflag_gen_chk #(
  parameter int DEPTH = 512,
  parameter int PW    = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_inc,
  input logic          rd_inc,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] occ,
  input logic          full_c,
  input logic          af_c,
  input logic          hf_c,
  input logic          ae_c,
  input logic          empty_c,
  input logic          sync_full,
  input logic          sync_empty,
  input logic          full,
  input logic          empty
);
  logic [1:0] wage, rage;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) wage <= 2'd0;
    else if (wage != 2'd3) wage <= wage + 2'd1;
  end
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rage <= 2'd0;
    else if (rage != 2'd3) rage <= rage + 2'd1;
  end

  assert_occ_bounded_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    32'(occ) <= DEPTH);

  assert_no_overflow_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full_c && wr_inc) |=> $stable(wptr));

  assert_no_underflow_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty_c && rd_inc) |=> $stable(rptr));

  assert_full_has_af_hf_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_c |-> (af_c && hf_c));

  assert_empty_has_ae_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty_c |-> ae_c);

  assert_sync_full_lag_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wage == 2'd3 && sync_full) |-> (full == $past(full_c, 2)));

  assert_sync_empty_lag_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rage == 2'd3 && sync_empty) |-> (empty == $past(empty_c, 2)));
endmodule

bind fflag_gen fflag_gen_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_inc(wr_inc), .rd_inc(rd_inc),
  .wptr(wptr), .rptr(rptr), .occ(occ),
  .full_c(full_c), .af_c(af_c), .hf_c(hf_c), .ae_c(ae_c), .empty_c(empty_c),
  .sync_full(flag_sync_mode[0]), .sync_empty(flag_sync_mode[4]),
  .full(full), .empty(empty)
);

// File: tb/fflag_gen_bench.sv
module fflag_gen_bench;
  localparam int D = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_inc, rd_inc, af_off_we, ae_off_we;
  logic [9:0] af_off_wdata, ae_off_wdata;
  logic [4:0] flag_sync_mode;
  logic       full, almost_full, half_full, almost_empty, empty;

  int occ_m, af_m, ae_m;
  logic [4:0] cur_m, d1_m, d2_m, mode;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fflag_gen u_fflag_gen (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_inc(wr_inc), .rd_inc(rd_inc),
    .af_off_we(af_off_we), .af_off_wdata(af_off_wdata),
    .ae_off_we(ae_off_we), .ae_off_wdata(ae_off_wdata),
    .flag_sync_mode(flag_sync_mode),
    .full(full), .almost_full(almost_full), .half_full(half_full),
    .almost_empty(almost_empty), .empty(empty)
  );

  function automatic logic [4:0] ref_flags(int o, int afo, int aeo);
    logic [4:0] f;
    f[4] = (o == 0);
    f[3] = (o <= aeo);
    f[2] = (2 * o > D);
    f[1] = ((D - o) <= afo);
    f[0] = (o == D);
    return f;
  endfunction

  function automatic string req_of(int i);
    case (i)
      0: return "R3";
      1: return "R6";
      2: return "R4";
      3: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic compare(input string ctx);
    logic [4:0] got, exp;
    got = {empty, almost_empty, half_full, almost_full, full};
    for (int i = 0; i < 5; i++) begin
      exp[i] = mode[i] ? d2_m[i] : cur_m[i];
      checks++;
      if (got[i] !== exp[i]) begin
        errors++;
        $display("FAIL %s%s (%s) flag %0d occ %0d: actual %b expected %b",
                 req_of(i), mode[i] ? "+R9" : "", ctx, i, occ_m, got[i], exp[i]);
      end
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic afwe, input int afv,
                     input logic aewe, input int aev, input string ctx);
    bit dw, dr;
    @(negedge clk);
    wr_inc = w; rd_inc = r;
    af_off_we = afwe; af_off_wdata = 10'(afv);
    ae_off_we = aewe; ae_off_wdata = 10'(aev);
    flag_sync_mode = mode;
    @(posedge clk);
    d2_m = d1_m;
    d1_m = cur_m;
    dw = w && (occ_m != D);
    dr = r && (occ_m != 0);
    occ_m = occ_m + int'(dw) - int'(dr);
    if (afwe) af_m = afv;
    if (aewe) ae_m = aev;
    cur_m = ref_flags(occ_m, af_m, ae_m);
    #2;
    compare(ctx);
  endtask

  task automatic step(input logic w, input logic r, input string ctx);
    cyc(w, r, 1'b0, 0, 1'b0, 0, ctx);
  endtask

  task automatic do_reset(input string ctx);
    @(negedge clk);
    rst_n = 1'b0;
    wr_inc = 0; rd_inc = 0; af_off_we = 0; ae_off_we = 0;
    af_off_wdata = '0; ae_off_wdata = '0;
    flag_sync_mode = mode;
    occ_m = 0; af_m = 8; ae_m = 8;
    cur_m = ref_flags(0, 8, 8);
    d1_m = cur_m; d2_m = cur_m;
    #1;
    compare(ctx);
    @(negedge clk);
    compare(ctx);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mode = 5'b00000;
    do_reset("R1 reset, direct mode");
    step(0, 0, "R1 after release");

    // Direct mode: fill, overrun, drain, underrun
    repeat (D) step(1, 0, "fill direct");
    step(1, 0, "R7 write at full");
    step(1, 1, "R10 both at full");
    step(1, 0, "refill");
    repeat (D) step(0, 1, "drain direct");
    step(0, 1, "R7 read at empty");
    step(1, 1, "R10 both at empty");
    step(0, 1, "back to empty");

    // Registered mode: partial fill, simultaneous strobes
    mode = 5'b11111;
    do_reset("R1 reset, registered mode");
    repeat (300) step(1, 0, "fill registered");
    repeat (20) step(1, 1, "R10 both mid-range");
    repeat (3) step(0, 0, "idle");
    repeat (300) step(0, 1, "drain registered");
    repeat (3) step(0, 0, "idle");

    // Threshold extremes with mixed modes
    mode = 5'b10101;
    cyc(0, 0, 1'b1, 0, 1'b1, D, "R8 thresholds 0 and 512");
    repeat (D) step(1, 0, "R8 fill extremes");
    repeat (D) step(0, 1, "R8 drain extremes");
    mode = 5'b01010;
    cyc(0, 0, 1'b1, 100, 1'b1, 3, "R8 thresholds 100 and 3");
    repeat (D) step(1, 0, "R8 fill mid thresholds");
    mode = 5'b10101;
    repeat (D) step(0, 1, "R9 mode change, drain");
    repeat (3) step(0, 0, "idle");

    // Reset mid-run restores thresholds to 8
    repeat (40) step(1, 0, "partial fill");
    do_reset("R1 reset mid-run");
    mode = 5'b00000;
    repeat (505) step(1, 0, "R1 default thresholds after reset");
    repeat (505) step(0, 1, "R1 default thresholds drain");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule